// File: doc/BRIEF.md
# Ternary Nonce Search Unit

This block searches for a proof-of-work nonce over a ternary sponge hash. Software or a loader first absorbs every part of the message except the nonce and hands the unit the resulting 729-trit sponge state, the midstate. After a start pulse, each iteration takes a copy of the midstate and overwrites trits 162 to 242 with an 81-trit nonce. It then applies the ternary round function a fixed number of times and inspects the low 243 trits of the result, which form the hash.

The nonce comes from a 64-bit linear feedback shift register rather than a ternary counter. Any bit pair that would form the illegal trit code is forced to zero. An iteration succeeds when every hash trit selected by a mask input is zero. Usually the mask covers a run of trailing trits, 14 or 15 of them. On success the unit raises a found flag and freezes the winning nonce. It also stops two counters: one counts evaluated hashes and the other counts elapsed search cycles. All three stay readable until the next start.

Top module: `trit_nonce_search`

## Requirements
- R1: After reset, `busy_o` and `found_o` are 0, and `nonce_o`, `hash_cnt_o` and `cycle_cnt_o` are all zero.
- R2: A trit is two bits: 2'b00 is 0, 2'b01 is +1, 2'b11 is -1, and 2'b10 is illegal. Trit k of a state occupies bits [2k+1:2k], and trit j of `nonce_o` occupies bits [2j+1:2j]. No nonce trit the unit produces is ever 2'b10.
- R3: A round maps state s to state n. For each i, n[i] = F[a + 3b + 4], where a = s[p(i)] and b = s[p(i+1)]. The tap sequence starts at p(0) = 0 and continues with p(j+1) = p(j) + 364 when p(j) < 365, and p(j) - 365 otherwise. F is (1, 0, -1, 1, -1, 0, -1, 1, 0). Each iteration applies ROUNDS rounds (default 81).
- R4: Each iteration starts from the stored midstate, with trit j of the current nonce written to state trit 162 + j for j = 0..80.
- R5: The shift register holds SEED after reset. Each iteration draws 162 bits by stepping it 162 times. On each step the feedback fb = s[63]^s[62]^s[60]^s[59] is shifted in at bit 0, and the fb of step i becomes raw bit i. A raw trit pair of 2'b10 is replaced by 2'b00. A start does not reseed the register.
- R6: An iteration succeeds when every trit i of the hash (state trits 0..242 after the rounds) whose `mask_i[i]` bit is 1 equals 2'b00.
- R7: An all-zero mask succeeds on the first iteration, giving a hash count of 1.
- R8: On success, `found_o` rises, `busy_o` falls, and `nonce_o` shows the winning nonce. All three, and both counters, hold until the next start.
- R9: `hash_cnt_o` counts evaluated iterations. `cycle_cnt_o` counts the cycles spent searching, which is ROUNDS+1 per iteration.
- R10: While a search runs, both `start_i` and `mid_load_i` are ignored, and the result matches the undisturbed search.
- R11: A start while idle clears `found_o` and both counters and raises `busy_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mid_load_i | input | 1 | Store `mid_state_i` as the midstate when idle |
| mid_state_i | input | 1458 | Midstate, 729 trits |
| mask_i | input | 243 | Hash trits that must be zero |
| start_i | input | 1 | Begin a search when idle |
| busy_o | output | 1 | Search in progress |
| found_o | output | 1 | Winning nonce available |
| nonce_o | output | 162 | Winning nonce, 81 trits |
| hash_cnt_o | output | 32 | Iterations evaluated in the last search |
| cycle_cnt_o | output | 32 | Cycles spent in the last search |

## Verification
The hardest case to reach from the ports is a start or midstate load that arrives part way through a multi-iteration search. If the design wrongly accepted either, the nonce stream or the midstate would shift, and the run would diverge from the model. The bench starts a search and, ten cycles later, pulses start while loading a different midstate. It then requires the nonce and both counts of the untouched search. The same bench-side model of the round function and the shift register also predicts the exact winning nonce and iteration count for several masks, including one that selects non-trailing trits and one that is all zero.

// File: rtl/tns_pkg.sv
package tns_pkg;

    localparam int STATE_TRITS = 729;
    localparam int HASH_TRITS  = 243;
    localparam int NONCE_TRITS = 81;
    localparam int NONCE_BASE  = 162;
    localparam int NONCE_BITS  = 2 * NONCE_TRITS;
    localparam int STATE_BITS  = 2 * STATE_TRITS;
    localparam int LFSR_W      = 64;
    localparam int HALF        = (STATE_TRITS - 1) / 2;

    typedef logic [1:0] trit_t;
    typedef trit_t [STATE_TRITS-1:0] state_t;
    typedef logic [NONCE_BITS-1:0] nonce_t;

    typedef enum logic {S_IDLE, S_RUN} phase_e;

    typedef struct packed {
        logic [LFSR_W-1:0] next;
        nonce_t            trits;
    } draw_t;

    localparam trit_t T_ZERO = 2'b00;
    localparam trit_t T_POS  = 2'b01;
    localparam trit_t T_NEG  = 2'b11;
    localparam trit_t T_BAD  = 2'b10;

    // closed form of the tap walk 0, 364, 728, 363, 727, ...
    function automatic int tap_pos(int i);
        if (i % 2 == 0) return (STATE_TRITS - i / 2) % STATE_TRITS;
        return HALF - (i - 1) / 2;
    endfunction

    function automatic int trit_val(trit_t t);
        case (t)
            T_POS:   return 1;
            T_NEG:   return -1;
            default: return 0;
        endcase
    endfunction

    function automatic trit_t sbox(trit_t a, trit_t b);
        int k;
        k = trit_val(a) + 3 * trit_val(b) + 4;
        case (k)
            0, 3, 7: return T_POS;
            2, 4, 6: return T_NEG;
            default: return T_ZERO;
        endcase
    endfunction

    function automatic draw_t lfsr_draw(logic [LFSR_W-1:0] cur);
        draw_t d;
        logic [LFSR_W-1:0] s;
        logic fb;
        s = cur;
        for (int i = 0; i < NONCE_BITS; i++) begin
            fb = s[63] ^ s[62] ^ s[60] ^ s[59];
            s  = {s[LFSR_W-2:0], fb};
            d.trits[i] = fb;
        end
        for (int j = 0; j < NONCE_TRITS; j++)
            if (d.trits[2*j +: 2] == T_BAD) d.trits[2*j +: 2] = T_ZERO;
        d.next = s;
        return d;
    endfunction

    function automatic logic nonce_legal(nonce_t n);
        for (int j = 0; j < NONCE_TRITS; j++)
            if (n[2*j +: 2] == T_BAD) return 1'b0;
        return 1'b1;
    endfunction

    function automatic state_t splice(state_t mid, nonce_t n);
        state_t s;
        s = mid;
        for (int j = 0; j < NONCE_TRITS; j++)
            s[NONCE_BASE + j] = n[2*j +: 2];
        return s;
    endfunction

endpackage

// File: rtl/tns_round.sv
module tns_round
    import tns_pkg::*;
(
    input  state_t cur_i,
    output state_t nxt_o
);
    for (genvar i = 0; i < STATE_TRITS; i++) begin : g_trit
        localparam int SA = tap_pos(i);
        localparam int SB = tap_pos(i + 1);
        assign nxt_o[i] = sbox(cur_i[SA], cur_i[SB]);
    end
endmodule

// File: rtl/tns_nonce_gen.sv
module tns_nonce_gen
    import tns_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 64'hACE1_2468_1357_9BDF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   adv_i,
    output nonce_t nonce_o
);
    logic [LFSR_W-1:0] lfsr_q;
    draw_t             draw_s;

    assign draw_s  = lfsr_draw(lfsr_q);
    assign nonce_o = draw_s.trits;

    always_ff @(posedge clk) begin
        if (rst)        lfsr_q <= SEED;
        else if (adv_i) lfsr_q <= draw_s.next;
    end

    // R2
    nonce_legal_chk: assert property (@(posedge clk) disable iff (rst)
        nonce_legal(nonce_o));

    // R5
    lfsr_alive_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);
endmodule

// File: rtl/tns_zero_chk.sv
module tns_zero_chk
    import tns_pkg::*;
(
    input  trit_t [HASH_TRITS-1:0] hash_i,
    input  logic  [HASH_TRITS-1:0] mask_i,
    output logic                   pass_o
);
    logic [HASH_TRITS-1:0] hit;
    for (genvar i = 0; i < HASH_TRITS; i++) begin : g_hit
        assign hit[i] = mask_i[i] & (|hash_i[i]);
    end
    assign pass_o = ~|hit;
endmodule

// File: rtl/trit_nonce_search.sv
module trit_nonce_search
    import tns_pkg::*;
#(
    parameter int                ROUNDS = 81,
    parameter int                CNT_W  = 32,
    parameter logic [LFSR_W-1:0] SEED   = 64'hACE1_2468_1357_9BDF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mid_load_i,
    input  logic [STATE_BITS-1:0]   mid_state_i,
    input  logic [HASH_TRITS-1:0]   mask_i,
    input  logic                    start_i,
    output logic                    busy_o,
    output logic                    found_o,
    output logic [NONCE_BITS-1:0]   nonce_o,
    output logic [CNT_W-1:0]        hash_cnt_o,
    output logic [CNT_W-1:0]        cycle_cnt_o
);
    localparam int RW = $clog2(ROUNDS + 1);
    localparam logic [RW-1:0] LAST = RW'(ROUNDS);

    phase_e          phase_q;
    state_t          mid_q, state_q, perm_s;
    nonce_t          cand_s, cur_q, win_q;
    logic [RW-1:0]   round_q;
    logic [CNT_W-1:0] hash_q, cyc_q;
    logic            found_q, pass_s, check_s, adv_s;

    tns_round u_round (.cur_i(state_q), .nxt_o(perm_s));

    tns_zero_chk u_zero (
        .hash_i (state_q[HASH_TRITS-1:0]),
        .mask_i (mask_i),
        .pass_o (pass_s)
    );

    tns_nonce_gen #(.SEED(SEED)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (adv_s),
        .nonce_o (cand_s)
    );

    assign check_s = (phase_q == S_RUN) && (round_q == LAST);
    assign adv_s   = ((phase_q == S_IDLE) && start_i) || (check_s && !pass_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= S_IDLE;
            mid_q   <= '0;
            state_q <= '0;
            cur_q   <= '0;
            win_q   <= '0;
            round_q <= '0;
            hash_q  <= '0;
            cyc_q   <= '0;
            found_q <= 1'b0;
        end else begin
            if (mid_load_i && phase_q == S_IDLE) mid_q <= mid_state_i;
            case (phase_q)
                S_IDLE: begin
                    if (start_i) begin
                        state_q <= splice(mid_q, cand_s);
                        cur_q   <= cand_s;
                        round_q <= '0;
                        hash_q  <= '0;
                        cyc_q   <= '0;
                        found_q <= 1'b0;
                        phase_q <= S_RUN;
                    end
                end
                S_RUN: begin
                    cyc_q <= cyc_q + CNT_W'(1);
                    if (check_s) begin
                        hash_q <= hash_q + CNT_W'(1);
                        if (pass_s) begin
                            found_q <= 1'b1;
                            win_q   <= cur_q;
                            phase_q <= S_IDLE;
                        end else begin
                            state_q <= splice(mid_q, cand_s);
                            cur_q   <= cand_s;
                            round_q <= '0;
                        end
                    end else begin
                        state_q <= perm_s;
                        round_q <= round_q + RW'(1);
                    end
                end
                default: phase_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o      = (phase_q == S_RUN);
    assign found_o     = found_q;
    assign nonce_o     = win_q;
    assign hash_cnt_o  = hash_q;
    assign cycle_cnt_o = cyc_q;

    // R8
    found_idle_chk: assert property (@(posedge clk) disable iff (rst)
        found_o |-> !busy_o);

    // R8
    found_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (found_o && !start_i) |=> (found_o && $stable(nonce_o)
            && $stable(hash_cnt_o) && $stable(cycle_cnt_o)));

    // R9
    cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (cycle_cnt_o == $past(cycle_cnt_o) + CNT_W'(1)));

    // R9
    cyc_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(found_o) |-> (cycle_cnt_o == hash_cnt_o * CNT_W'(ROUNDS + 1)));

    // R11
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && !found_o
            && hash_cnt_o == '0 && cycle_cnt_o == '0));

    // R10
    run_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !check_s) |=> $stable(hash_cnt_o));
endmodule

// File: tb/trit_nonce_search_tb.sv
module trit_nonce_search_tb;
    localparam logic [63:0] SEED = 64'hACE1_2468_1357_9BDF;
    localparam int ROUNDS = 81;
    localparam int SB = 1458;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mid_load = 1'b0;
    logic [SB-1:0] mid_state = '0;
    logic [242:0] mask = '0;
    logic start = 1'b0;
    logic busy, found;
    logic [161:0] nonce;
    logic [31:0] hash_cnt, cycle_cnt;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_lfsr;
    int ftab [9] = '{1, 0, -1, 1, -1, 0, -1, 1, 0};

    always #10 clk = ~clk;

    trit_nonce_search #(.ROUNDS(ROUNDS), .CNT_W(32), .SEED(SEED)) u_dut (
        .clk(clk), .rst(rst), .mid_load_i(mid_load), .mid_state_i(mid_state),
        .mask_i(mask), .start_i(start), .busy_o(busy), .found_o(found),
        .nonce_o(nonce), .hash_cnt_o(hash_cnt), .cycle_cnt_o(cycle_cnt));

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int dec(logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    function automatic logic [1:0] enc(int v);
        if (v > 0) return 2'b01;
        if (v < 0) return 2'b11;
        return 2'b00;
    endfunction

    function automatic logic [SB-1:0] m_round(logic [SB-1:0] s);
        logic [SB-1:0] n;
        int p, pn;
        p = 0;
        for (int i = 0; i < 729; i++) begin
            pn = (p < 365) ? p + 364 : p - 365;
            n[2*i +: 2] = enc(ftab[dec(s[2*p +: 2]) + 3 * dec(s[2*pn +: 2]) + 4]);
            p = pn;
        end
        return n;
    endfunction

    function automatic logic [SB-1:0] mk_mid(int k);
        logic [SB-1:0] m;
        for (int t = 0; t < 729; t++)
            m[2*t +: 2] = enc(((t * k + t / 7 + k) % 3) - 1);
        return m;
    endfunction

    function automatic bit legal(logic [161:0] n);
        for (int j = 0; j < 81; j++)
            if (n[2*j +: 2] == 2'b10) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_search(input logic [SB-1:0] mid, input logic [242:0] msk,
                                output logic [161:0] wn, output int hc);
        logic [161:0] raw;
        logic [SB-1:0] s;
        logic fb;
        bit ok;
        hc = 0;
        ok = 1'b0;
        wn = '0;
        while (!ok && hc < 4000) begin
            for (int i = 0; i < 162; i++) begin
                fb = m_lfsr[63] ^ m_lfsr[62] ^ m_lfsr[60] ^ m_lfsr[59];
                m_lfsr = {m_lfsr[62:0], fb};
                raw[i] = fb;
            end
            for (int j = 0; j < 81; j++)
                if (raw[2*j +: 2] == 2'b10) raw[2*j +: 2] = 2'b00;
            s = mid;
            for (int j = 0; j < 81; j++) s[2*(162 + j) +: 2] = raw[2*j +: 2];
            for (int r = 0; r < ROUNDS; r++) s = m_round(s);
            hc++;
            ok = 1'b1;
            for (int i = 0; i < 243; i++)
                if (msk[i] && s[2*i +: 2] != 2'b00) ok = 1'b0;
            wn = raw;
        end
    endtask

    task automatic wait_found();
        int n = 0;
        while (!found && n < 60000) begin
            @(negedge clk);
            n++;
        end
        chk(found, "R8 found raised", {255'b0, found}, 256'd1);
    endtask

    task automatic check_result(input string tag, input logic [161:0] wn, input int hc);
        chk(nonce == wn, {tag, " R3/R4/R5 winning nonce"}, nonce, wn);
        chk(legal(nonce), {tag, " R2 nonce legal"}, nonce, wn);
        chk(hash_cnt == hc, {tag, " R9 hash count"}, hash_cnt, hc);
        chk(cycle_cnt == hc * (ROUNDS + 1), {tag, " R9 cycle count"}, cycle_cnt,
            hc * (ROUNDS + 1));
        chk(!busy, {tag, " R8 idle after success"}, busy, 0);
    endtask

    task automatic load_mid(input logic [SB-1:0] m);
        @(negedge clk);
        mid_load = 1'b1;
        mid_state = m;
        @(negedge clk);
        mid_load = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk(!busy, "R1 busy", busy, 0);
        chk(!found, "R1 found", found, 0);
        chk(nonce == '0, "R1 nonce", nonce, 0);
        chk(hash_cnt == 0, "R1 hash count", hash_cnt, 0);
        chk(cycle_cnt == 0, "R1 cycle count", cycle_cnt, 0);
    endtask

    task automatic t_search(input string tag, input logic [SB-1:0] mid,
                            input logic [242:0] msk);
        logic [161:0] wn;
        int hc;
        model_search(mid, msk, wn, hc);
        load_mid(mid);
        mask = msk;
        pulse_start();
        wait_found();
        check_result(tag, wn, hc);
    endtask

    task automatic t_zero_mask();
        logic [161:0] wn;
        int hc;
        model_search(mk_mid(5), '0, wn, hc);
        load_mid(mk_mid(5));
        mask = '0;
        pulse_start();
        wait_found();
        chk(hash_cnt == 1, "R7 zero mask single hash", hash_cnt, 1);
        check_result("R7", wn, hc);
    endtask

    task automatic t_hold();
        logic [161:0] n0;
        logic [31:0] h0, c0;
        n0 = nonce; h0 = hash_cnt; c0 = cycle_cnt;
        repeat (25) @(negedge clk);
        chk(found, "R8 found held", found, 1);
        chk(nonce == n0, "R8 nonce held", nonce, n0);
        chk(hash_cnt == h0 && cycle_cnt == c0, "R8 counters frozen",
            {hash_cnt, cycle_cnt}, {h0, c0});
    endtask

    task automatic t_disturb();
        logic [161:0] wn;
        int hc;
        logic [242:0] msk;
        msk = '0;
        msk[242:241] = 2'b11;
        model_search(mk_mid(11), msk, wn, hc);
        load_mid(mk_mid(11));
        mask = msk;
        pulse_start();
        repeat (10) @(negedge clk);
        chk(busy, "R10 busy before disturbance", busy, 1);
        start = 1'b1;
        mid_load = 1'b1;
        mid_state = mk_mid(17);
        @(negedge clk);
        start = 1'b0;
        mid_load = 1'b0;
        wait_found();
        check_result("R10", wn, hc);
    endtask

    task automatic t_restart();
        logic [161:0] wn;
        int hc;
        logic [242:0] msk;
        msk = '0;
        msk[242:241] = 2'b11;
        model_search(mk_mid(11), msk, wn, hc);
        mask = msk;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R11 busy after start", busy, 1);
        chk(!found, "R11 found cleared", found, 0);
        chk(hash_cnt == 0 && cycle_cnt == 0, "R11 counters cleared",
            {hash_cnt, cycle_cnt}, 0);
        wait_found();
        check_result("R11", wn, hc);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [242:0] m;
        m_lfsr = SEED;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero_mask();
        m = '0; m[242:241] = 2'b11;
        t_search("R6 trailing two", mk_mid(1), m);
        t_hold();
        m = '0; m[242:240] = 3'b111;
        t_search("R6 trailing three", mk_mid(2), m);
        m = '0; m[0] = 1'b1; m[100] = 1'b1;
        t_search("R6 scattered", mk_mid(4), m);
        t_disturb();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule